// File: doc/BRIEF.md
# Squelch Qualification and Auto Low-Power Control

This block decides, for each lane of a four-lane signal redriver, when the transmitter should hold its output at the idle level and when the lane may drop into a reduced-power state. Each lane has a squelch comparator that reports a raw "input below threshold" level. The block synchronizes these levels and qualifies them with two separate quiet-time counters. A short window declares the lane idle. A much longer window, which is only armed after the device has been active long enough and the low-power strap is set, requests low power. The first synchronized sample that shows activity releases both at once.

A mirror strap makes lane 0 the only squelch source. Lanes 1 to 3 then follow lane 0's qualified state, and their detector enables are dropped so that their comparators can be powered down. The block also turns a three-level threshold strap into a two-bit code for the analog comparator. All timing windows are parameters counted in clock cycles. At 100 MHz the defaults are 2 cycles for idle entry (20 ns), 100 cycles for low-power entry (1 µs) and 25,000,000 cycles for the active qualification (250 ms). The release path is two synchronizer flops plus one state flop, which is 30 ns.

Top module: `eilp_ctrl`

## Requirements
- R1: With the device active, a lane's `tx_idle_o` bit rises on the clock edge that registers its IDLE_CYC-th consecutive synchronized quiet sample. The synchronizer is SYNC_STAGES flops deep and a raw bit of 1 means quiet.
- R2: A synchronized active sample (raw bit 0) clears that lane's `tx_idle_o` and `lp_req_o` on the next edge. From the raw input, the release therefore takes SYNC_STAGES+1 cycles.
- R3: A single active sample restarts both quiet counters, so entry needs a fresh full window after any glitch.
- R4: Low power is permitted only while `alp_en_i` is 1 and `dev_active_i` has been 1 for at least ACT_CYC consecutive cycles. A drop of `dev_active_i` restarts this qualification.
- R5: While low power is permitted, a lane's `lp_req_o` bit rises on the edge that registers its LP_CYC-th consecutive permitted quiet sample.
- R6: With `alp_en_i` at 0, `lp_req_o` stays 0 while idle detection still operates.
- R7: With `mirror_i` at 1, lanes 1 to 3 take their idle and low-power state from lane 0's synchronized squelch, and `sq_det_en_o` is 4'b0001. With `mirror_i` at 0, `sq_det_en_o` is 4'b1111.
- R8: `thr_code_o` decodes `thr_sel_i` = {driven, level}: 2'b00 and 2'b01 (undriven, mid level) give 1 (61 mVpp); 2'b10 gives 0 (47 mVpp); 2'b11 gives 2 (83 mVpp).
- R9: While `dev_active_i` is 0, `tx_idle_o` and `lp_req_o` are cleared on the next edge and all quiet counters restart.
- R10: During and right after reset, `tx_idle_o` and `lp_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sq_raw_i | input | NCH | Raw squelch level per lane, 1 = below threshold |
| dev_active_i | input | 1 | Device is in the active state |
| alp_en_i | input | 1 | Auto low-power enable strap |
| mirror_i | input | 1 | Lane 0 squelch drives all lanes |
| thr_sel_i | input | 2 | Threshold strap {driven, level} |
| tx_idle_o | output | NCH | Force transmitter to idle, per lane |
| lp_req_o | output | NCH | Low-power request, per lane |
| sq_det_en_o | output | NCH | Squelch detector enable, per lane |
| thr_code_o | output | 2 | Encoded threshold: 0=47, 1=61, 2=83 mVpp |

## Verification
On every cycle, the embedded assertions check three things. An active sample releases idle and low power on the next edge. Idle and low-power can only rise after a quiet sample that was permitted. The qualification flag and all lane outputs fall cleanly when the device goes inactive. The exact entry cycle after a full quiet window can only be shown by the bench scenarios, because that cycle depends on counts longer than a property can see. The same holds for the restart after a one-sample glitch, the restart of the active qualification, and mirror-mode following with lanes that disagree. For those, the bench's behavioural model is compared with the outputs cycle by cycle.

// File: rtl/eilp_pkg.sv
package eilp_pkg;

    localparam logic [1:0] THR_CODE_LOW  = 2'd0;
    localparam logic [1:0] THR_CODE_MID  = 2'd1;
    localparam logic [1:0] THR_CODE_HIGH = 2'd2;

    typedef enum logic [1:0] {
        SEL_OPEN_A = 2'b00,
        SEL_OPEN_B = 2'b01,
        SEL_LOW    = 2'b10,
        SEL_HIGH   = 2'b11
    } thr_sel_e;

    function automatic logic [1:0] thr_encode(input logic [1:0] sel);
        logic [1:0] code;
        case (thr_sel_e'(sel))
            SEL_LOW:  code = THR_CODE_LOW;
            SEL_HIGH: code = THR_CODE_HIGH;
            default:  code = THR_CODE_MID;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/eilp_sync.sv
module eilp_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/eilp_active_qual.sv
module eilp_active_qual #(
    parameter int ACT_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic ok_o
);
    localparam int CW = $clog2(ACT_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            st_d.cnt = '0;
            st_d.ok  = 1'b0;
        end else if (!st_q.ok) begin
            if (st_q.cnt == CW'(ACT_CYC - 1)) st_d.ok = 1'b1;
            else                             st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ok_o = st_q.ok;

    // R4
    qual_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ok) |-> $past(active_i));

    // R4
    qual_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !st_q.ok);
endmodule

// File: rtl/eilp_chan.sv
module eilp_chan #(
    parameter int IDLE_CYC = 2,
    parameter int LP_CYC   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic quiet_i,
    input  logic lp_allow_i,
    output logic idle_o,
    output logic lp_o
);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam int LW = $clog2(LP_CYC + 1);

    typedef struct packed {
        logic [IW-1:0] idle_cnt;
        logic          idle;
        logic [LW-1:0] lp_cnt;
        logic          lp;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!act_i || !quiet_i) begin
            st_d = '0;
        end else begin
            if (!st_q.idle) begin
                if (st_q.idle_cnt == IW'(IDLE_CYC - 1)) st_d.idle = 1'b1;
                else                                    st_d.idle_cnt = st_q.idle_cnt + 1'b1;
            end
            if (!lp_allow_i) begin
                st_d.lp_cnt = '0;
                st_d.lp     = 1'b0;
            end else if (!st_q.lp) begin
                if (st_q.lp_cnt == LW'(LP_CYC - 1)) st_d.lp = 1'b1;
                else                                st_d.lp_cnt = st_q.lp_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle_o = st_q.idle;
    assign lp_o   = st_q.lp;

    // R2
    exit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet_i |=> (!idle_o && !lp_o));

    // R1
    idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(quiet_i && act_i));

    // R5
    lp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_o) |-> $past(quiet_i && lp_allow_i));
endmodule

// File: rtl/eilp_ctrl.sv
module eilp_ctrl #(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int IDLE_CYC    = 2,
    parameter int LP_CYC      = 100,
    parameter int ACT_CYC     = 25_000_000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sq_raw_i,
    input  logic           dev_active_i,
    input  logic           alp_en_i,
    input  logic           mirror_i,
    input  logic [1:0]     thr_sel_i,
    output logic [NCH-1:0] tx_idle_o,
    output logic [NCH-1:0] lp_req_o,
    output logic [NCH-1:0] sq_det_en_o,
    output logic [1:0]     thr_code_o
);
    import eilp_pkg::*;

    logic [NCH-1:0] sq_sync;
    logic [NCH-1:0] quiet_eff;
    logic           act_ok;
    logic           lp_allow;

    eilp_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sq_raw_i),
        .dout (sq_sync)
    );

    eilp_active_qual #(.ACT_CYC(ACT_CYC)) i_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(dev_active_i),
        .ok_o    (act_ok)
    );

    assign lp_allow = alp_en_i && act_ok;

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        if (k == 0) begin : g_lead
            assign quiet_eff[k]   = sq_sync[0];
            assign sq_det_en_o[k] = 1'b1;
        end else begin : g_follow
            assign quiet_eff[k]   = mirror_i ? sq_sync[0] : sq_sync[k];
            assign sq_det_en_o[k] = !mirror_i;
        end

        eilp_chan #(.IDLE_CYC(IDLE_CYC), .LP_CYC(LP_CYC)) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (dev_active_i),
            .quiet_i   (quiet_eff[k]),
            .lp_allow_i(lp_allow),
            .idle_o    (tx_idle_o[k]),
            .lp_o      (lp_req_o[k])
        );
    end

    assign thr_code_o = thr_encode(thr_sel_i);

    // R9
    inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_active_i |=> (tx_idle_o == '0 && lp_req_o == '0));

    // R6
    alp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alp_en_i |=> (lp_req_o == '0));

    // R8
    thr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_code_o != 2'd3);
endmodule

// File: tb/test_eilp_ctrl.sv
module test_eilp_ctrl;
    localparam int NCH = 4;
    localparam int SYN = 2;
    localparam int IDL = 3;
    localparam int LPC = 12;
    localparam int ACT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] raw = '0;
    logic dev_act = 1'b0, alp_en = 1'b0, mirror = 1'b0;
    logic [1:0] thr_sel = 2'b00;
    logic [NCH-1:0] tx_idle, lp_req, det_en;
    logic [1:0] thr_code;

    int tests = 0, fails = 0;
    string cur_req = "R10";
    bit done = 1'b0;

    always #5 clk = ~clk;

    eilp_ctrl #(.NCH(NCH), .SYNC_STAGES(SYN), .IDLE_CYC(IDL), .LP_CYC(LPC), .ACT_CYC(ACT)) i_eilp_ctrl (
        .clk(clk), .rst_n(rst_n), .sq_raw_i(raw), .dev_active_i(dev_act),
        .alp_en_i(alp_en), .mirror_i(mirror), .thr_sel_i(thr_sel),
        .tx_idle_o(tx_idle), .lp_req_o(lp_req), .sq_det_en_o(det_en), .thr_code_o(thr_code)
    );

    // behavioural reference
    int dly[$];
    int run[NCH], lprun[NCH];
    int act_run;
    logic [NCH-1:0] exp_idle, exp_lp;

    function automatic logic [1:0] exp_thr(input logic [1:0] s);
        if (s == 2'b10) return 2'd0;
        if (s == 2'b11) return 2'd2;
        return 2'd1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            dly = {};
            for (int i = 0; i < SYN; i++) dly.push_back(0);
            for (int k = 0; k < NCH; k++) begin run[k] = 0; lprun[k] = 0; end
            act_run = 0; exp_idle = '0; exp_lp = '0;
        end else begin
            bit allow;
            int s;
            allow = alp_en && (act_run >= ACT);
            s = dly[0];
            for (int k = 0; k < NCH; k++) begin
                bit q;
                q = mirror ? s[0] : s[k];
                if (!dev_act || !q) begin
                    run[k] = 0; lprun[k] = 0;
                end else begin
                    run[k]++;
                    if (allow) lprun[k]++; else lprun[k] = 0;
                end
                exp_idle[k] = run[k] >= IDL;
                exp_lp[k]   = lprun[k] >= LPC;
            end
            act_run = dev_act ? act_run + 1 : 0;
            void'(dly.pop_front());
            dly.push_back(int'(raw));
        end
    end

    always @(posedge clk) begin
        #1;
        if (!done) begin
            logic [NCH-1:0] exp_en;
            exp_en = mirror ? NCH'(1) : '1;
            tests++;
            if (tx_idle !== exp_idle || lp_req !== exp_lp) begin
                fails++;
                $display("FAIL %s idle/lp actual=%b/%b expected=%b/%b t=%0t",
                         cur_req, tx_idle, lp_req, exp_idle, exp_lp, $time);
            end
            tests++;
            if (det_en !== exp_en) begin
                fails++;
                $display("FAIL R7 det_en actual=%b expected=%b", det_en, exp_en);
            end
            tests++;
            if (thr_code !== exp_thr(thr_sel)) begin
                fails++;
                $display("FAIL R8 thr_code actual=%0d expected=%0d", thr_code, exp_thr(thr_sel));
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        tests++;
        if (tx_idle !== '0 || lp_req !== '0) begin
            fails++;
            $display("FAIL R10 reset actual=%b/%b expected=0000/0000", tx_idle, lp_req);
        end
        rst_n = 1'b1;
        cur_req = "R10"; step(3);

        cur_req = "R1_R6"; dev_act = 1'b1; raw = 4'b1111; step(25);
        cur_req = "R3_R2"; raw = 4'b1011; step(1); raw = 4'b1111; step(10);
        cur_req = "R2"; raw = 4'b0101; step(8); raw = 4'b1111; step(6);
        cur_req = "R8";
        for (int i = 0; i < 4; i++) begin thr_sel = 2'(i); step(2); end
        cur_req = "R4_R5"; alp_en = 1'b1; step(60);
        cur_req = "R3"; raw = 4'b1110; step(1); raw = 4'b1111; step(20);
        cur_req = "R2"; raw = 4'b0000; step(5); raw = 4'b1111; step(20);
        cur_req = "R9"; dev_act = 1'b0; step(4);
        cur_req = "R4"; dev_act = 1'b1; step(60);
        cur_req = "R6"; alp_en = 1'b0; step(10); alp_en = 1'b1; step(20);
        cur_req = "R7"; mirror = 1'b1; raw = 4'b0001; step(25);
        raw = 4'b1110; step(10);
        raw = 4'b1111; step(8); raw = 4'b0000; step(5);
        mirror = 1'b0; raw = 4'b1010; step(20);
        cur_req = "R9"; dev_act = 1'b0; step(5);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL R10 watchdog actual=timeout expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule